// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins an A bus and a B bus through a set of independent lanes (two lanes of eight bits by default). Each lane can pass data straight across in either direction, capture the level on either bus into a lane register, or drive a captured value onto the opposite bus. Each lane has its own drive enables, source selects and capture strobes, so one lane can be isolated while the other is moving data.

Each bus is modelled as three signals: the external value, the external enable, and the block's own value and enable. From these the block forms a resolved pin value. A keeper per bus holds the last resolved level when nothing drives the bus. The lane registers always sample the resolved pin, even while the block itself drives that pin. This lets one bus's data be written into both registers in a single capture.

The capture strobes are sampled by the single system clock. A strobe that was low at one clock and is high at the next counts as a capture edge.

Top module: `dxr_xcvr`

## Requirements
- R1: Every lane acts only on its own controls; a strobe, enable or select on one lane leaves the other lane's registers and drive unchanged.
- R2: With `b_drv_en` low and `a_drv_n` high, a lane drives neither bus (`a_oe` and `b_oe` are both 0).
- R3: `b_oe` follows `b_drv_en` (active high) and `a_oe` is the inverse of `a_drv_n` (active low), in the same cycle.
- R4: A capture edge on `a_stb` loads the resolved A pin into the A register. A capture edge on `b_stb` loads the resolved B pin into the B register. A capture edge means the strobe is high at this clock and was low at the previous clock. The new value shows at the outputs from the next cycle.
- R5: With no capture edge, a register keeps its value, even if the strobe stays high and the bus data changes.
- R6: When `b_sel_reg` is 0, `b_out` is the A bus value in the same cycle; when it is 1, `b_out` is the A register. `a_sel_reg` selects between the live B value and the B register for `a_out` in the same way.
- R7: With both enables active and both selects at 1, the A register drives B and the B register drives A at the same time.
- R8: When B is driven live from A and both strobes rise together, both registers load the A value. When A is driven live from B and both strobes rise together, both registers load the B value.
- R9: Capture does not depend on the output enables, and it samples the resolved pin even when the block drives that pin.
- R10: When both strobes rise together with both selects at 1, each register loads the value that stood on its pin before the edge, so the two registers swap. Copying one register into the other takes strobes in two separate cycles.
- R11: When neither the block nor the external source drives a bus, its resolved value stays at the last resolved level, and a new external value with its enable low has no effect.
- R12: When the block and the external source drive the same bus of a lane, that lane's `clash` bit is 1 and the resolved pin takes the block's value.
- R13: Reset (synchronous, active high) clears both registers of every lane, the bus keepers and the strobe history to zero.
- R14: The live path onto one bus takes the other bus's external value, or its kept value when nothing external drives it. It never takes the block's own drive on that other bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| b_drv_en | input | LANES | Per lane: drive B bus (active high) |
| a_drv_n | input | LANES | Per lane: drive A bus (active low) |
| b_sel_reg | input | LANES | Per lane: B output source, 0 = live A, 1 = A register |
| a_sel_reg | input | LANES | Per lane: A output source, 0 = live B, 1 = B register |
| a_stb | input | LANES | Per lane: capture strobe for the A register |
| b_stb | input | LANES | Per lane: capture strobe for the B register |
| a_ext_oe | input | LANES | Per lane: external source drives A |
| a_ext_val | input | LANES*LANE_W | External value on A |
| b_ext_oe | input | LANES | Per lane: external source drives B |
| b_ext_val | input | LANES*LANE_W | External value on B |
| a_out | output | LANES*LANE_W | Block's drive value for A |
| a_oe | output | LANES | Block drives A |
| a_pin | output | LANES*LANE_W | Resolved A bus value |
| b_out | output | LANES*LANE_W | Block's drive value for B |
| b_oe | output | LANES | Block drives B |
| b_pin | output | LANES*LANE_W | Resolved B bus value |
| clash | output | LANES | Per lane: block and external source drive the same bus |

## Verification
The registers cannot be read directly. A wrong register value is seen only when its select is 1 and its bus enable is on: it then appears on `a_out`/`b_out` in that same cycle. Any capture error therefore shows one cycle after the edge, once the lane is switched to stored data. A stale or wrong keeper shows on the resolved pin in the first undriven cycle. A wrong strobe history shows as a missing or extra capture, which the later stored-data readout of the affected lane reveals.

// File: rtl/dxr_pkg.sv
package dxr_pkg;

   typedef enum logic {
      SRC_LIVE   = 1'b0,
      SRC_STORED = 1'b1
   } dxr_src_e;

   function automatic logic rise(input logic now_v, input logic prev_v);
      return now_v & ~prev_v;
   endfunction

endpackage

// File: rtl/dxr_strobe_edge.sv
module dxr_strobe_edge (
   input  logic clk,
   input  logic rst,
   input  logic stb,
   output logic fire
);
   logic stb_q;

   always_ff @(posedge clk) begin
      if (rst) stb_q <= 1'b0;
      else     stb_q <= stb;
   end

   assign fire = dxr_pkg::rise(stb, stb_q);
endmodule

// File: rtl/dxr_bus_side.sv
module dxr_bus_side #(
   parameter int W    = 8,
   parameter int KEEP = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         own_oe,
   input  logic [W-1:0] own_val,
   input  logic         ext_oe,
   input  logic [W-1:0] ext_val,
   output logic [W-1:0] pin,
   output logic [W-1:0] far,
   output logic         clash
);
   generate
      if (KEEP != 0) begin : g_keep
         logic [W-1:0] keep_q;
         always_ff @(posedge clk) begin
            if (rst) keep_q <= '0;
            else     keep_q <= pin;
         end
         assign far = ext_oe ? ext_val : keep_q;
      end else begin : g_nokeep
         assign far = ext_oe ? ext_val : '0;
      end
   endgenerate

   assign pin   = own_oe ? own_val : far;
   assign clash = own_oe & ext_oe;
endmodule

// File: rtl/dxr_lane.sv
module dxr_lane #(
   parameter int W    = 8,
   parameter int KEEP = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         b_drv_en,
   input  logic         a_drv_n,
   input  logic         b_sel,
   input  logic         a_sel,
   input  logic         a_stb,
   input  logic         b_stb,
   input  logic         a_ext_oe,
   input  logic [W-1:0] a_ext_val,
   input  logic         b_ext_oe,
   input  logic [W-1:0] b_ext_val,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   output logic [W-1:0] a_pin,
   output logic [W-1:0] b_out,
   output logic         b_oe,
   output logic [W-1:0] b_pin,
   output logic         clash
);
   import dxr_pkg::*;

   logic [W-1:0] a_far, b_far;
   logic [W-1:0] a_reg, b_reg;
   logic         a_fire, b_fire;
   logic         a_clash, b_clash;
   dxr_src_e     b_src, a_src;

   dxr_strobe_edge u_a_edge (.clk(clk), .rst(rst), .stb(a_stb), .fire(a_fire));
   dxr_strobe_edge u_b_edge (.clk(clk), .rst(rst), .stb(b_stb), .fire(b_fire));

   assign b_src = dxr_src_e'(b_sel);
   assign a_src = dxr_src_e'(a_sel);

   // live paths take the far side value so that the two directions never loop
   assign b_out = (b_src == SRC_STORED) ? a_reg : a_far;
   assign a_out = (a_src == SRC_STORED) ? b_reg : b_far;
   assign b_oe  = b_drv_en;
   assign a_oe  = ~a_drv_n;

   dxr_bus_side #(.W(W), .KEEP(KEEP)) u_a_side (
      .clk(clk), .rst(rst), .own_oe(a_oe), .own_val(a_out),
      .ext_oe(a_ext_oe), .ext_val(a_ext_val),
      .pin(a_pin), .far(a_far), .clash(a_clash));

   dxr_bus_side #(.W(W), .KEEP(KEEP)) u_b_side (
      .clk(clk), .rst(rst), .own_oe(b_oe), .own_val(b_out),
      .ext_oe(b_ext_oe), .ext_val(b_ext_val),
      .pin(b_pin), .far(b_far), .clash(b_clash));

   always_ff @(posedge clk) begin
      if (rst) begin
         a_reg <= '0;
         b_reg <= '0;
      end else begin
         if (a_fire) a_reg <= a_pin;
         if (b_fire) b_reg <= b_pin;
      end
   end

   assign clash = a_clash | b_clash;
endmodule

// File: rtl/dxr_xcvr.sv
module dxr_xcvr #(
   parameter int LANES    = 2,
   parameter int LANE_W   = 8,
   parameter int BUS_HOLD = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [LANES-1:0]        b_drv_en,
   input  logic [LANES-1:0]        a_drv_n,
   input  logic [LANES-1:0]        b_sel_reg,
   input  logic [LANES-1:0]        a_sel_reg,
   input  logic [LANES-1:0]        a_stb,
   input  logic [LANES-1:0]        b_stb,
   input  logic [LANES-1:0]        a_ext_oe,
   input  logic [LANES*LANE_W-1:0] a_ext_val,
   input  logic [LANES-1:0]        b_ext_oe,
   input  logic [LANES*LANE_W-1:0] b_ext_val,
   output logic [LANES*LANE_W-1:0] a_out,
   output logic [LANES-1:0]        a_oe,
   output logic [LANES*LANE_W-1:0] a_pin,
   output logic [LANES*LANE_W-1:0] b_out,
   output logic [LANES-1:0]        b_oe,
   output logic [LANES*LANE_W-1:0] b_pin,
   output logic [LANES-1:0]        clash
);
   localparam int BUS_W = LANES * LANE_W;

   generate
      if (LANES < 1)                         begin : g_bad_lanes $error("LANES must be at least 1"); end
      if (LANE_W < 1)                        begin : g_bad_width $error("LANE_W must be at least 1"); end
      if (BUS_HOLD != 0 && BUS_HOLD != 1)    begin : g_bad_hold  $error("BUS_HOLD must be 0 or 1"); end
      if (BUS_W > 4096)                      begin : g_bad_total $error("bus too wide"); end

      for (genvar g = 0; g < LANES; g++) begin : g_lane
         dxr_lane #(.W(LANE_W), .KEEP(BUS_HOLD)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .b_drv_en (b_drv_en[g]),
            .a_drv_n  (a_drv_n[g]),
            .b_sel    (b_sel_reg[g]),
            .a_sel    (a_sel_reg[g]),
            .a_stb    (a_stb[g]),
            .b_stb    (b_stb[g]),
            .a_ext_oe (a_ext_oe[g]),
            .a_ext_val(a_ext_val[g*LANE_W +: LANE_W]),
            .b_ext_oe (b_ext_oe[g]),
            .b_ext_val(b_ext_val[g*LANE_W +: LANE_W]),
            .a_out    (a_out[g*LANE_W +: LANE_W]),
            .a_oe     (a_oe[g]),
            .a_pin    (a_pin[g*LANE_W +: LANE_W]),
            .b_out    (b_out[g*LANE_W +: LANE_W]),
            .b_oe     (b_oe[g]),
            .b_pin    (b_pin[g*LANE_W +: LANE_W]),
            .clash    (clash[g]));
      end
   endgenerate
endmodule

// File: rtl/dxr_xcvr_chk.sv
module dxr_xcvr_chk #(
   parameter int LANES    = 2,
   parameter int LANE_W   = 8,
   parameter int BUS_HOLD = 1
) (
   input logic                    clk,
   input logic                    rst,
   input logic [LANES-1:0]        b_drv_en,
   input logic [LANES-1:0]        a_drv_n,
   input logic [LANES-1:0]        b_sel_reg,
   input logic [LANES-1:0]        a_sel_reg,
   input logic [LANES-1:0]        a_stb,
   input logic [LANES-1:0]        b_stb,
   input logic [LANES-1:0]        a_ext_oe,
   input logic [LANES-1:0]        b_ext_oe,
   input logic [LANES*LANE_W-1:0] a_out,
   input logic [LANES-1:0]        a_oe,
   input logic [LANES*LANE_W-1:0] a_pin,
   input logic [LANES*LANE_W-1:0] b_out,
   input logic [LANES-1:0]        b_oe,
   input logic [LANES*LANE_W-1:0] b_pin,
   input logic [LANES-1:0]        clash
);
   generate
      for (genvar i = 0; i < LANES; i++) begin : g_chk
         // R2
         isolate_chk: assert property (@(posedge clk) disable iff (rst)
            (!b_drv_en[i] && a_drv_n[i]) |-> (!a_oe[i] && !b_oe[i]));

         // R12
         a_clash_chk: assert property (@(posedge clk) disable iff (rst)
            (a_oe[i] && a_ext_oe[i]) |-> (clash[i] && a_pin[i*LANE_W +: LANE_W] == a_out[i*LANE_W +: LANE_W]));

         // R12
         b_clash_chk: assert property (@(posedge clk) disable iff (rst)
            (b_oe[i] && b_ext_oe[i]) |-> (clash[i] && b_pin[i*LANE_W +: LANE_W] == b_out[i*LANE_W +: LANE_W]));

         // R6
         live_ab_chk: assert property (@(posedge clk) disable iff (rst)
            (b_oe[i] && !b_sel_reg[i] && !a_oe[i] && !b_ext_oe[i]) |-> (b_pin[i*LANE_W +: LANE_W] == a_pin[i*LANE_W +: LANE_W]));

         // R6
         live_ba_chk: assert property (@(posedge clk) disable iff (rst)
            (a_oe[i] && !a_sel_reg[i] && !b_oe[i] && !a_ext_oe[i]) |-> (a_pin[i*LANE_W +: LANE_W] == b_pin[i*LANE_W +: LANE_W]));

         // R4
         store_a_chk: assert property (@(posedge clk) disable iff (rst)
            (a_stb[i] && !$past(a_stb[i])) ##1 (b_drv_en[i] && b_sel_reg[i])
            |-> (b_out[i*LANE_W +: LANE_W] == $past(a_pin[i*LANE_W +: LANE_W])));

         // R4
         store_b_chk: assert property (@(posedge clk) disable iff (rst)
            (b_stb[i] && !$past(b_stb[i])) ##1 (!a_drv_n[i] && a_sel_reg[i])
            |-> (a_out[i*LANE_W +: LANE_W] == $past(b_pin[i*LANE_W +: LANE_W])));

         if (BUS_HOLD != 0) begin : g_hold
            // R11
            a_hold_chk: assert property (@(posedge clk) disable iff (rst)
               (!$past(rst) && !a_oe[i] && !a_ext_oe[i]) |-> (a_pin[i*LANE_W +: LANE_W] == $past(a_pin[i*LANE_W +: LANE_W])));
            // R11
            b_hold_chk: assert property (@(posedge clk) disable iff (rst)
               (!$past(rst) && !b_oe[i] && !b_ext_oe[i]) |-> (b_pin[i*LANE_W +: LANE_W] == $past(b_pin[i*LANE_W +: LANE_W])));
         end
      end
   endgenerate
endmodule

bind dxr_xcvr dxr_xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W), .BUS_HOLD(BUS_HOLD)) u_chk (
   .clk(clk), .rst(rst), .b_drv_en(b_drv_en), .a_drv_n(a_drv_n),
   .b_sel_reg(b_sel_reg), .a_sel_reg(a_sel_reg), .a_stb(a_stb), .b_stb(b_stb),
   .a_ext_oe(a_ext_oe), .b_ext_oe(b_ext_oe), .a_out(a_out), .a_oe(a_oe),
   .a_pin(a_pin), .b_out(b_out), .b_oe(b_oe), .b_pin(b_pin), .clash(clash));

// File: tb/dxr_xcvr_bench.sv
`timescale 1ns/1ps
module dxr_xcvr_bench;
   localparam int LN = 2;
   localparam int LW = 8;

   logic              clk = 1'b0;
   logic              rst;
   logic [LN-1:0]     b_drv_en, a_drv_n, b_sel_reg, a_sel_reg, a_stb, b_stb;
   logic [LN-1:0]     a_ext_oe, b_ext_oe;
   logic [LN*LW-1:0]  a_ext_val, b_ext_val;
   logic [LN*LW-1:0]  a_out, a_pin, b_out, b_pin;
   logic [LN-1:0]     a_oe, b_oe, clash;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   dxr_xcvr #(.LANES(LN), .LANE_W(LW), .BUS_HOLD(1)) u_dxr_xcvr (
      .clk(clk), .rst(rst), .b_drv_en(b_drv_en), .a_drv_n(a_drv_n),
      .b_sel_reg(b_sel_reg), .a_sel_reg(a_sel_reg), .a_stb(a_stb), .b_stb(b_stb),
      .a_ext_oe(a_ext_oe), .a_ext_val(a_ext_val), .b_ext_oe(b_ext_oe), .b_ext_val(b_ext_val),
      .a_out(a_out), .a_oe(a_oe), .a_pin(a_pin), .b_out(b_out), .b_oe(b_oe),
      .b_pin(b_pin), .clash(clash));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(); @(posedge clk); #1; endtask
   task automatic look(); #2; endtask

   task automatic isolate();
      b_drv_en = '0; a_drv_n = '1; b_sel_reg = '0; a_sel_reg = '0;
      a_ext_oe = '0; b_ext_oe = '0;
   endtask

   task automatic pulse(input logic [LN-1:0] am, input logic [LN-1:0] bm);
      a_stb = am; b_stb = bm; tick();
      a_stb = '0; b_stb = '0; tick();
   endtask

   task automatic read_stored_lane0();
      b_drv_en = 2'b01; b_sel_reg = 2'b01; a_drv_n = 2'b10; a_sel_reg = 2'b01;
      a_ext_oe = '0; b_ext_oe = '0;
      look();
   endtask

   task automatic t_reset();
      look();
      chk("R13 a keeper", {8'h0, a_pin[7:0]}, 16'h0);
      chk("R13 b keeper", {8'h0, b_pin[7:0]}, 16'h0);
      chk("R13 clash", {14'h0, clash}, 16'h0);
      b_drv_en = '1; b_sel_reg = '1; a_drv_n = '0; a_sel_reg = '1;
      look();
      chk("R13 A regs", b_out, 16'h0);
      chk("R13 B regs", a_out, 16'h0);
      isolate();
   endtask

   task automatic t_indep();
      a_ext_oe = '1; a_ext_val = {8'hE1, 8'h44};
      pulse(2'b10, 2'b00);
      a_ext_oe = '0; b_drv_en = 2'b11; b_sel_reg = 2'b11;
      look();
      chk("R1 lane1 captured", {8'h0, b_out[15:8]}, 16'h00E1);
      chk("R1 lane0 untouched", {8'h0, b_out[7:0]}, 16'h0000);
      b_drv_en = 2'b01;
      look();
      chk("R1 per-lane enable", {14'h0, b_oe}, 16'h0001);
      isolate();
   endtask

   task automatic t_isolate();
      look();
      chk("R2 isolation", {12'h0, a_oe, b_oe}, 16'h0);
      b_drv_en = 2'b01; a_drv_n = 2'b01;
      look();
      chk("R3 b enable polarity", {14'h0, b_oe}, 16'h0001);
      chk("R3 a enable polarity", {14'h0, a_oe}, 16'h0002);
      isolate();
   endtask

   task automatic t_live();
      a_ext_oe = 2'b01; a_ext_val[7:0] = 8'h5A; b_drv_en = 2'b01;
      look();
      chk("R6 live A to B", {8'h0, b_pin[7:0]}, 16'h005A);
      a_ext_val[7:0] = 8'h6B;
      look();
      chk("R6 live same cycle", {8'h0, b_out[7:0]}, 16'h006B);
      a_ext_val[7:0] = 8'h11; b_ext_oe = 2'b01; b_ext_val[7:0] = 8'h22; a_drv_n = 2'b10;
      look();
      chk("R12 block wins on B", {8'h0, b_pin[7:0]}, 16'h0011);
      chk("R14 A driven from far B", {8'h0, a_pin[7:0]}, 16'h0022);
      chk("R12 clash flags", {14'h0, clash}, 16'h0001);
      isolate();
   endtask

   task automatic t_store();
      a_ext_oe = 2'b01; a_ext_val[7:0] = 8'h3C;
      b_ext_oe = 2'b01; b_ext_val[7:0] = 8'h96;
      a_stb = 2'b01; b_stb = 2'b01; tick();
      a_ext_val[7:0] = 8'h00; b_ext_val[7:0] = 8'hFF;
      tick(); tick();
      a_stb = '0; b_stb = '0; tick();
      read_stored_lane0();
      chk("R4 A register", {8'h0, b_out[7:0]}, 16'h003C);
      chk("R5 B register held", {8'h0, a_out[7:0]}, 16'h0096);
      chk("R7 stored on both buses", {a_pin[7:0], b_pin[7:0]}, 16'h963C);
      isolate();
   endtask

   task automatic t_hold();
      a_ext_oe = 2'b01; a_ext_val[7:0] = 8'h77; tick();
      a_ext_oe = '0; a_ext_val[7:0] = 8'h00; tick(); tick();
      look();
      chk("R11 keeper holds A", {8'h0, a_pin[7:0]}, 16'h0077);
   endtask

   task automatic t_both();
      a_ext_oe = 2'b01; a_ext_val[7:0] = 8'hA5; b_drv_en = 2'b01;
      pulse(2'b01, 2'b01);
      read_stored_lane0();
      chk("R8 A into A register", {8'h0, b_out[7:0]}, 16'h00A5);
      chk("R9 own-driven B captured", {8'h0, a_out[7:0]}, 16'h00A5);
      isolate();
      b_ext_oe = 2'b01; b_ext_val[7:0] = 8'h5C; a_drv_n = 2'b10;
      pulse(2'b01, 2'b01);
      read_stored_lane0();
      chk("R8 B into A register", {8'h0, b_out[7:0]}, 16'h005C);
      chk("R8 B into B register", {8'h0, a_out[7:0]}, 16'h005C);
      isolate();
   endtask

   task automatic t_swap();
      a_ext_oe = 2'b01; a_ext_val[7:0] = 8'h12;
      b_ext_oe = 2'b01; b_ext_val[7:0] = 8'h34;
      pulse(2'b01, 2'b01);
      read_stored_lane0();
      chk("R10 preload", {a_out[7:0], b_out[7:0]}, 16'h3412);
      pulse(2'b01, 2'b01);
      look();
      chk("R10 simultaneous swaps", {a_out[7:0], b_out[7:0]}, 16'h1234);
      pulse(2'b00, 2'b01);
      look();
      chk("R10 staggered copy", {a_out[7:0], b_out[7:0]}, 16'h3434);
      isolate();
   endtask

   initial begin
      rst = 1'b1;
      a_stb = '0; b_stb = '0; a_ext_val = '0; b_ext_val = '0;
      isolate();
      tick(); tick(); tick();
      rst = 1'b0;
      t_reset();
      t_indep();
      t_isolate();
      t_live();
      t_store();
      t_hold();
      t_both();
      t_swap();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule